// File: doc/BRIEF.md
# Multi-Phase Reset Sequencer

This block steps a chip through its reset in five phases and decides when the system is released. It runs from the free-running internal oscillator clock. It takes three kinds of reset request: destructive, external and functional. Each source has its own mask bit, and each functional source has its own "short" configuration bit. Each phase has a minimum dwell count, and some phases also wait for the flash initialization handshake. Only the final idle phase releases the system.

A destructive request that is not masked throws the sequencer back to the power-up phase at once, with no clock needed. An external request, or a functional request not configured as short, restarts the long path at the first reset phase. A short functional request arriving from idle skips ahead to the last phase, so the recovery is brief. A sticky status bit records every accepted request until software clears it with a write-one-to-clear vector.

Top module: `rst_seq_fsm`

## Requirements
- R1: The sequencer leaves the power-up phase (code 0) for phase 1 only at a rising edge where `osc_ok_i` and `vreg_ok_i` are both high and at least P0_MIN (3) edges have passed since `rst_ni` or the last unmasked destructive request deasserted.
- R2: A full event is an unmasked external request, or an unmasked functional request whose short bit is 0. A full event sampled in phase 1, 2, 3 or idle moves the sequencer to phase 1 at that edge. A full event in phase 0 leaves the phase unchanged.
- R3: Phase 1 advances to phase 2 exactly P1_MIN (350) edges after its entry or after its last full event, whichever is later. Each full event in phase 1 restarts this count.
- R4: Phase 2 advances to phase 3 no earlier than P2_MIN (8) edges after entry, and only at an edge where `flash_done_i` is high.
- R5: A short event (an unmasked functional request with short bit 1) sampled in idle moves the sequencer to phase 3. In phase 3 a short event restarts the phase 3 count. In phases 0, 1 and 2 a short event has no effect on the phase or the timing.
- R6: Phase 3 advances to idle no earlier than P3_MIN (40) edges after its entry or its last short event, and only at an edge where `flash_done_i` is high.
- R7: An unmasked destructive request forces phase 0 asynchronously and holds it there while the request stays asserted.
- R8: A request whose mask bit is 1 has no effect on the phase or on the status bits.
- R9: `flash_start_o` is high for exactly the first cycle after entry to phase 2 and the first cycle after a direct entry to phase 3 from idle. It stays low when phase 3 is entered from phase 2.
- R10: `sys_rst_o` is high in every phase except idle, including during `rst_ni` low and during a destructive request.
- R11: `stat_o` holds one sticky bit per source: bits [N_DEST-1:0] for destructive, then N_EXT bits for external, then N_FUNC bits for functional. A bit is set at every edge where its unmasked request is high. A bit is cleared by a 1 in the same position of `stat_clr_i`, and setting wins over clearing. Only `rst_ni` resets the bits.
- R12: When a full event and a short event are sampled at the same edge, the full event decides the next phase.
- R13: `phase_o` encodes phase 0..3 as 0..3 and idle as 4. After `rst_ni` goes low it reads 0, with `stat_o` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Internal oscillator clock |
| rst_ni | input | 1 | Power-on reset, active low, asynchronous |
| osc_ok_i | input | 1 | Oscillator stable |
| vreg_ok_i | input | 1 | Supply voltage good |
| dest_req_i | input | N_DEST | Destructive reset requests |
| dest_mask_i | input | N_DEST | 1 ignores the matching destructive source |
| ext_req_i | input | N_EXT | External reset requests |
| ext_mask_i | input | N_EXT | 1 ignores the matching external source |
| func_req_i | input | N_FUNC | Functional reset requests |
| func_mask_i | input | N_FUNC | 1 ignores the matching functional source |
| func_short_i | input | N_FUNC | 1 routes the functional source to the short path |
| flash_done_i | input | 1 | Flash initialization complete |
| stat_clr_i | input | N_DEST+N_EXT+N_FUNC | Write-one-to-clear for the status bits |
| phase_o | output | 3 | Current phase code |
| sys_rst_o | output | 1 | System held in reset |
| flash_start_o | output | 1 | One-cycle flash initialization start |
| stat_o | output | N_DEST+N_EXT+N_FUNC | Sticky per-source status |

## Verification
Phase changes, the start pulse and the status bits all become visible one rising edge after the request or condition is sampled. A destructive request is the exception: it drives phase 0 with no clock. The bench changes inputs on the falling edge. A behavioural model updates on each rising edge, and every output is compared with it 1 ns after that edge. Dwell checks count falling edges from the first cycle a phase code is seen. That count equals the minimum dwell when the exit is not stalled, which pins the exact exit edge for the 3, 350, 8 and 40 cycle limits and the restart cases.

// File: rtl/rst_seq_pkg.sv
package rst_seq_pkg;

  typedef enum logic [2:0] {
    PH_0    = 3'd0,
    PH_1    = 3'd1,
    PH_2    = 3'd2,
    PH_3    = 3'd3,
    PH_IDLE = 3'd4
  } phase_e;

  function automatic int max_of(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/rst_evt_qual.sv
module rst_evt_qual #(
  parameter int N_DEST = 2,
  parameter int N_EXT  = 2,
  parameter int N_FUNC = 4,
  localparam int N_SRC = N_DEST + N_EXT + N_FUNC
) (
  input  logic [N_DEST-1:0] dest_req_i,
  input  logic [N_DEST-1:0] dest_mask_i,
  input  logic [N_EXT-1:0]  ext_req_i,
  input  logic [N_EXT-1:0]  ext_mask_i,
  input  logic [N_FUNC-1:0] func_req_i,
  input  logic [N_FUNC-1:0] func_mask_i,
  input  logic [N_FUNC-1:0] func_short_i,
  output logic              dest_any_o,
  output logic              full_any_o,
  output logic              short_any_o,
  output logic [N_SRC-1:0]  hit_o
);

  logic [N_DEST-1:0] dest_hit;
  logic [N_EXT-1:0]  ext_hit;
  logic [N_FUNC-1:0] func_hit, func_full, func_short;

  assign dest_hit = dest_req_i & ~dest_mask_i;
  assign ext_hit  = ext_req_i & ~ext_mask_i;

  for (genvar i = 0; i < N_FUNC; i++) begin : g_func
    assign func_hit[i]   = func_req_i[i] & ~func_mask_i[i];
    assign func_full[i]  = func_hit[i] & ~func_short_i[i];
    assign func_short[i] = func_hit[i] &  func_short_i[i];
  end

  assign dest_any_o  = |dest_hit;
  assign full_any_o  = (|ext_hit) | (|func_full);
  assign short_any_o = |func_short;
  assign hit_o       = {func_hit, ext_hit, dest_hit};

endmodule

// File: rtl/rst_dwell_cnt.sv
module rst_dwell_cnt #(
  parameter int CNT_W = 10
) (
  input  logic             clk_i,
  input  logic             arst_ni,
  input  logic             restart_i,
  input  logic [CNT_W-1:0] lim_i,
  output logic             done_o
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge arst_ni) begin
    if (!arst_ni)            cnt_q <= '0;
    else if (restart_i)      cnt_q <= '0;
    else if (cnt_q != '1)    cnt_q <= cnt_q + 1'b1;
  end

  assign done_o = (cnt_q >= lim_i);

  // saturate, never wrap past the top
  AST_CNT_SAT: assert property (@(posedge clk_i) disable iff (!arst_ni)
    (cnt_q == '1 && !restart_i) |=> (cnt_q == '1)); // R3

endmodule

// File: rtl/rst_status.sv
module rst_status #(
  parameter int N = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] q_o
);

  logic [N-1:0] q_q;

  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       q_q[i] <= 1'b0;
      else if (set_i[i]) q_q[i] <= 1'b1;
      else if (clr_i[i]) q_q[i] <= 1'b0;
    end
  end

  assign q_o = q_q;

  AST_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((q_o & ~clr_i) != '0) |=> ((q_o & $past(q_o & ~clr_i)) == $past(q_o & ~clr_i))); // R11
  AST_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i != '0) |=> ((q_o & $past(set_i)) == $past(set_i))); // R11

endmodule

// File: rtl/rst_seq_fsm.sv
module rst_seq_fsm
  import rst_seq_pkg::*;
#(
  parameter int N_DEST = 2,
  parameter int N_EXT  = 2,
  parameter int N_FUNC = 4,
  parameter int P0_MIN = 3,
  parameter int P1_MIN = 350,
  parameter int P2_MIN = 8,
  parameter int P3_MIN = 40,
  localparam int N_SRC   = N_DEST + N_EXT + N_FUNC,
  localparam int MAX_MIN = max_of(max_of(P0_MIN, P1_MIN), max_of(P2_MIN, P3_MIN)),
  localparam int CNT_W   = $clog2(MAX_MIN) + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              osc_ok_i,
  input  logic              vreg_ok_i,
  input  logic [N_DEST-1:0] dest_req_i,
  input  logic [N_DEST-1:0] dest_mask_i,
  input  logic [N_EXT-1:0]  ext_req_i,
  input  logic [N_EXT-1:0]  ext_mask_i,
  input  logic [N_FUNC-1:0] func_req_i,
  input  logic [N_FUNC-1:0] func_mask_i,
  input  logic [N_FUNC-1:0] func_short_i,
  input  logic              flash_done_i,
  input  logic [N_SRC-1:0]  stat_clr_i,
  output logic [2:0]        phase_o,
  output logic              sys_rst_o,
  output logic              flash_start_o,
  output logic [N_SRC-1:0]  stat_o
);

  logic             dest_any, full_any, short_any;
  logic [N_SRC-1:0] hit;

  rst_evt_qual #(
    .N_DEST(N_DEST), .N_EXT(N_EXT), .N_FUNC(N_FUNC)
  ) u_qual (
    .dest_req_i  (dest_req_i),
    .dest_mask_i (dest_mask_i),
    .ext_req_i   (ext_req_i),
    .ext_mask_i  (ext_mask_i),
    .func_req_i  (func_req_i),
    .func_mask_i (func_mask_i),
    .func_short_i(func_short_i),
    .dest_any_o  (dest_any),
    .full_any_o  (full_any),
    .short_any_o (short_any),
    .hit_o       (hit)
  );

  // power-on or destructive request clears the sequencer without a clock
  logic arst_n;
  assign arst_n = rst_ni & ~dest_any;

  phase_e           state_q, state_d;
  logic             restart, start_d, start_q, cnt_done, past_vld;
  logic [CNT_W-1:0] lim;

  always_comb begin
    case (state_q)
      PH_0:    lim = CNT_W'(P0_MIN - 1);
      PH_1:    lim = CNT_W'(P1_MIN - 1);
      PH_2:    lim = CNT_W'(P2_MIN - 1);
      PH_3:    lim = CNT_W'(P3_MIN - 1);
      default: lim = '0;
    endcase
  end

  rst_dwell_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i    (clk_i),
    .arst_ni  (arst_n),
    .restart_i(restart),
    .lim_i    (lim),
    .done_o   (cnt_done)
  );

  always_comb begin
    state_d = state_q;
    restart = 1'b0;
    start_d = 1'b0;
    case (state_q)
      PH_0: begin
        if (cnt_done && osc_ok_i && vreg_ok_i) begin
          state_d = PH_1;
          restart = 1'b1;
        end
      end
      PH_1: begin
        if (full_any) begin
          restart = 1'b1;
        end else if (cnt_done) begin
          state_d = PH_2;
          restart = 1'b1;
          start_d = 1'b1;
        end
      end
      PH_2: begin
        if (full_any) begin
          state_d = PH_1;
          restart = 1'b1;
        end else if (cnt_done && flash_done_i) begin
          state_d = PH_3;
          restart = 1'b1;
        end
      end
      PH_3: begin
        if (full_any) begin
          state_d = PH_1;
          restart = 1'b1;
        end else if (short_any) begin
          restart = 1'b1;
        end else if (cnt_done && flash_done_i) begin
          state_d = PH_IDLE;
          restart = 1'b1;
        end
      end
      default: begin
        if (full_any) begin
          state_d = PH_1;
          restart = 1'b1;
        end else if (short_any) begin
          state_d = PH_3;
          restart = 1'b1;
          start_d = 1'b1;
        end
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge arst_n) begin
    if (!arst_n) begin
      state_q  <= PH_0;
      start_q  <= 1'b0;
      past_vld <= 1'b0;
    end else begin
      state_q  <= state_d;
      start_q  <= start_d;
      past_vld <= 1'b1;
    end
  end

  rst_status #(.N(N_SRC)) u_stat (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (hit),
    .clr_i (stat_clr_i),
    .q_o   (stat_o)
  );

  assign phase_o       = state_q;
  assign sys_rst_o     = (state_q != PH_IDLE);
  assign flash_start_o = start_q;

  AST_P0_EXIT_OK: assert property (@(posedge clk_i) disable iff (!arst_n)
    (past_vld && state_q == PH_1 && $past(state_q) == PH_0) |-> $past(osc_ok_i && vreg_ok_i)); // R1
  AST_FULL_TO_P1: assert property (@(posedge clk_i) disable iff (!arst_n)
    (past_vld && $past(full_any) && $past(state_q) != PH_0) |-> (state_q == PH_1)); // R2
  AST_P2_EXIT_FLASH: assert property (@(posedge clk_i) disable iff (!arst_n)
    (past_vld && state_q == PH_3 && $past(state_q) == PH_2) |-> $past(flash_done_i)); // R4
  AST_P3_ENTRY: assert property (@(posedge clk_i) disable iff (!arst_n)
    (past_vld && state_q == PH_3 && $past(state_q) != PH_3)
      |-> ($past(state_q) == PH_2 || ($past(state_q) == PH_IDLE && $past(short_any)))); // R5
  AST_IDLE_ENTRY: assert property (@(posedge clk_i) disable iff (!arst_n)
    (past_vld && state_q == PH_IDLE && $past(state_q) != PH_IDLE)
      |-> ($past(state_q) == PH_3 && $past(flash_done_i))); // R6
  AST_START_ONE: assert property (@(posedge clk_i) disable iff (!arst_n)
    flash_start_o |=> !flash_start_o); // R9
  AST_START_CAUSE: assert property (@(posedge clk_i) disable iff (!arst_n)
    (past_vld && flash_start_o)
      |-> ((state_q == PH_2 && $past(state_q) == PH_1) ||
           (state_q == PH_3 && $past(state_q) == PH_IDLE))); // R9

endmodule

// File: tb/rst_seq_fsm_test.sv
`timescale 1ns/1ps
module rst_seq_fsm_test;

  localparam int ND = 2, NE = 2, NF = 4, NS = ND + NE + NF;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          osc_ok_i = 1'b0, vreg_ok_i = 1'b0, flash_done_i = 1'b1;
  logic [ND-1:0] dest_req_i = '0, dest_mask_i = '0;
  logic [NE-1:0] ext_req_i = '0, ext_mask_i = '0;
  logic [NF-1:0] func_req_i = '0, func_mask_i = '0, func_short_i = '0;
  logic [NS-1:0] stat_clr_i = '0;
  logic [2:0]    phase_o;
  logic          sys_rst_o, flash_start_o;
  logic [NS-1:0] stat_o;

  rst_seq_fsm uut (.*);

  always #2 clk_i = ~clk_i;

  int    total = 0, bad = 0;
  string tag = "R13";

  task automatic chk(input string t, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", t, act, exp);
    end
  endtask

  // behavioural reference
  int            m_ph = 0, m_dw = 0;
  logic          m_fs = 1'b0;
  logic [NS-1:0] m_st = '0;

  always @(posedge clk_i) begin
    logic [NS-1:0] acc;
    logic d_any, f_any, s_any, rs, nfs;
    int nph;
    acc   = {func_req_i & ~func_mask_i, ext_req_i & ~ext_mask_i, dest_req_i & ~dest_mask_i};
    d_any = |(dest_req_i & ~dest_mask_i);
    f_any = (|(ext_req_i & ~ext_mask_i)) | (|(func_req_i & ~func_mask_i & ~func_short_i));
    s_any = |(func_req_i & ~func_mask_i & func_short_i);
    if (!rst_ni) begin
      m_ph = 0; m_dw = 0; m_fs = 0; m_st = '0;
    end else begin
      m_st = (m_st & ~stat_clr_i) | acc;
      if (d_any) begin
        m_ph = 0; m_dw = 0; m_fs = 0;
      end else begin
        nph = m_ph; rs = 0; nfs = 0;
        if (m_ph == 0) begin
          if (m_dw >= 2 && osc_ok_i && vreg_ok_i) begin nph = 1; rs = 1; end
        end else if (f_any) begin
          nph = 1; rs = 1;
        end else if (m_ph == 1) begin
          if (m_dw >= 349) begin nph = 2; rs = 1; nfs = 1; end
        end else if (m_ph == 2) begin
          if (m_dw >= 7 && flash_done_i) begin nph = 3; rs = 1; end
        end else if (m_ph == 3) begin
          if (s_any) rs = 1;
          else if (m_dw >= 39 && flash_done_i) begin nph = 4; rs = 1; end
        end else if (s_any) begin
          nph = 3; rs = 1; nfs = 1;
        end
        m_ph = nph;
        m_dw = rs ? 0 : m_dw + 1;
        m_fs = nfs;
      end
    end
    #1;
    chk({tag, " phase"}, phase_o, m_ph);
    chk("R10 sys_rst", sys_rst_o, (m_ph != 4));
    chk("R9 flash_start", flash_start_o, m_fs);
    chk("R11 status", stat_o, m_st);
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic wait_ph(input int p, output int n);
    n = 0;
    while (phase_o != p && n < 2000) begin
      @(negedge clk_i);
      n++;
    end
  endtask

  initial begin
    #400000;
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int n;
    step(3);
    chk("R13 reset phase", phase_o, 0);
    chk("R13 reset status", stat_o, 0);
    chk("R10 reset sys_rst", sys_rst_o, 1);
    rst_ni = 1'b1;
    tag = "R1";
    step(10);
    chk("R1 hold without osc", phase_o, 0);
    osc_ok_i = 1'b1; vreg_ok_i = 1'b1;
    wait_ph(1, n); chk("R1 exit after ok", n, 1);
    tag = "R3";
    wait_ph(2, n); chk("R3 p1 dwell", n, 350);
    chk("R9 start on p2", flash_start_o, 1);
    tag = "R4";
    wait_ph(3, n); chk("R4 p2 dwell", n, 8);
    chk("R9 no start p2->p3", flash_start_o, 0);
    tag = "R6";
    wait_ph(4, n); chk("R6 p3 dwell", n, 40);
    chk("R10 idle release", sys_rst_o, 0);

    tag = "R2";
    ext_req_i[0] = 1'b1; step(1); ext_req_i[0] = 1'b0;
    chk("R2 ext to p1", phase_o, 1);
    chk("R11 ext0 bit", stat_o, 8'h04);
    tag = "R3";
    step(100);
    func_req_i[1] = 1'b1; step(1); func_req_i[1] = 1'b0;
    wait_ph(2, n); chk("R3 restart dwell", n, 350);
    flash_done_i = 1'b0; tag = "R4";
    step(20);
    chk("R4 stall without flash", phase_o, 2);
    flash_done_i = 1'b1;
    wait_ph(3, n); chk("R4 exit on flash", n, 1);
    wait_ph(4, n); chk("R6 p3 dwell again", n, 40);

    tag = "R5";
    func_short_i[2] = 1'b1;
    func_req_i[2] = 1'b1; step(1); func_req_i[2] = 1'b0;
    chk("R5 short to p3", phase_o, 3);
    chk("R9 start on short", flash_start_o, 1);
    step(20);
    func_req_i[2] = 1'b1; step(1); func_req_i[2] = 1'b0;
    wait_ph(4, n); chk("R5 short restart", n, 40);

    tag = "R12";
    ext_req_i[1] = 1'b1; func_req_i[2] = 1'b1; step(1);
    ext_req_i[1] = 1'b0; func_req_i[2] = 1'b0;
    chk("R12 full wins", phase_o, 1);
    tag = "R5";
    step(10);
    func_req_i[2] = 1'b1; step(1); func_req_i[2] = 1'b0;
    chk("R5 short absorbed", phase_o, 1);
    wait_ph(2, n); chk("R5 no restart in p1", n, 339);
    wait_ph(4, n);

    tag = "R11";
    stat_clr_i = '1; step(1); stat_clr_i = '0;
    chk("R11 clear all", stat_o, 0);
    tag = "R8";
    ext_mask_i[0] = 1'b1; ext_req_i[0] = 1'b1; step(1); ext_req_i[0] = 1'b0;
    step(1);
    chk("R8 masked ext phase", phase_o, 4);
    chk("R8 masked ext status", stat_o, 0);
    dest_mask_i[1] = 1'b1; dest_req_i[1] = 1'b1; step(1); dest_req_i[1] = 1'b0;
    chk("R8 masked dest phase", phase_o, 4);
    chk("R8 masked dest status", stat_o, 0);

    tag = "R11";
    ext_req_i[1] = 1'b1; stat_clr_i = '1; step(1);
    ext_req_i[1] = 1'b0; stat_clr_i = '0;
    chk("R11 set wins", stat_o, 8'h08);
    tag = "R7";
    step(5);
    dest_req_i[0] = 1'b1;
    #1;
    chk("R7 async p0", phase_o, 0);
    chk("R10 sys_rst in p0", sys_rst_o, 1);
    step(4);
    chk("R7 held p0", phase_o, 0);
    dest_req_i[0] = 1'b0;
    tag = "R1";
    wait_ph(1, n); chk("R1 p0 dwell", n, 3);
    chk("R11 dest bit", stat_o, 8'h09);
    step(2);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule